// File: doc/BRIEF.md
# Pluggable optical module bring-up sequencer

This block sits on the host side of a pluggable optical module and walks it from insertion to a configured state with fixed receive-path equalization. While no module is present, it holds the module in low-power mode and in reset. Once a module is detected, it releases reset and waits a settling time long enough for the module's management interface to come up. It then issues four single-byte register writes through a request/acknowledge port to an external two-wire bus master. The writes disable the transmitters, select the equalization page, and load the two packed equalization bytes. When the last write is acknowledged, the sequencer leaves low-power mode and reports done.

The module's equalization registers are volatile. The sequence therefore runs again from the start after every controller reset, after every removal and re-insertion, and after a restart from the error state. The host supplies four 4-bit lane codes. Any code outside the legal 0 to 10 dB range is limited before it is written, and that event is recorded in a sticky flag.

Top module: `optmod_bringup`

## Requirements
- R1: While rst_ni is low, and in the hold state entered when present_i is low, the block drives lpmode_o=1, modrst_no=0, wr_req_o=0, done_o=0 and fault_o=0.
- R2: In the cycle after present_i is seen high in the hold state, modrst_no goes to 1. The first write request appears exactly WAIT_CYCLES = CLK_HZ/1000*WAIT_MS cycles after that.
- R3: The writes are issued in a fixed order as (wr_addr_o, wr_data_o) pairs: (86, 0x0F), (127, 0x03), (234, {lane1, lane2}), (235, {lane3, lane4}). The first lane of each pair goes in the upper nibble. Lane k (k = 1..4) is taken from eq_code_i[4k-1:4k-4].
- R4: A request stays asserted with an unchanged address until wr_ack_i or wr_err_i is seen. Each acknowledge advances the sequence by exactly one write.
- R5: A lane code above 10 (0xA) is written as 10. Codes 0 to 10 are written unchanged.
- R6: eq_clamp_o becomes 1 when a write of byte 234 or 235 containing a limited lane is acknowledged. It then stays 1 until rst_ni is asserted.
- R7: After the fourth acknowledge, done_o=1, lpmode_o=0, modrst_no=1, and no further request is made while the module stays present.
- R8: wr_err_i during a request sets fault_o=1, wr_req_o=0, modrst_no=0 and lpmode_o=1. This state is held until restart_i is seen, and the block then returns to hold and reruns the full sequence.
- R9: When present_i is low at any clock edge, the next cycle shows the hold outputs. A later insertion reruns the full sequence, including the wait.
- R10: When wr_err_i and wr_ack_i are both high in the same cycle, the error takes priority: fault_o=1 and no further write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| present_i | input | 1 | Module present, high when inserted |
| restart_i | input | 1 | Leave the error state and restart the sequence |
| eq_code_i | input | 16 | Four 4-bit lane equalization codes, lane 1 in bits 3:0 |
| wr_ack_i | input | 1 | Bus master has completed the current write |
| wr_err_i | input | 1 | Bus master reports a failed write |
| lpmode_o | output | 1 | Module low-power control, active high |
| modrst_no | output | 1 | Module reset, active low |
| wr_req_o | output | 1 | Write request to the bus master |
| wr_addr_o | output | 8 | Register byte address of the write |
| wr_data_o | output | 8 | Data byte of the write |
| done_o | output | 1 | Module configured |
| fault_o | output | 1 | Sequencer halted by a bus error |
| eq_clamp_o | output | 1 | Sticky flag: an out-of-range lane code was limited |

## Verification
The bench builds the block with CLK_HZ=1000 and WAIT_MS=20, which gives a 20-cycle settling wait in place of 500 million cycles. At that length the exact wait boundary can be measured on every pass. Many full bring-ups, removals during the wait and during writes, and error/restart cycles all fit in a short run. With random acknowledge delays and random lane codes, both in range and reserved, the bench checks request holding, nibble packing and the limiting rule on every pass.

// File: rtl/optmod_bringup_pkg.sv
package optmod_bringup_pkg;
  localparam int unsigned NUM_LANES = 4;
  localparam int unsigned CODE_W    = 4;
  localparam logic [CODE_W-1:0] EQ_MAX = 4'd10;

  localparam logic [7:0] ADDR_TXDIS = 8'd86;
  localparam logic [7:0] ADDR_PAGE  = 8'd127;
  localparam logic [7:0] ADDR_EQ_A  = 8'd234;
  localparam logic [7:0] ADDR_EQ_B  = 8'd235;
  localparam logic [7:0] DATA_TXDIS = 8'h0F;
  localparam logic [7:0] DATA_PAGE  = 8'h03;

  typedef enum logic [2:0] {
    ST_HOLD, ST_WAIT, ST_TXDIS, ST_PAGE, ST_EQ_A, ST_EQ_B, ST_DONE, ST_ERR
  } seq_state_e;
endpackage

// File: rtl/optmod_wait_timer.sv
module optmod_wait_timer #(
  parameter int unsigned WAIT_CYCLES = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i)          cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);

  p_cnt_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_cnt_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/optmod_eq_clamp.sv
module optmod_eq_clamp
  import optmod_bringup_pkg::*;
(
  input  logic [NUM_LANES*CODE_W-1:0] code_i,
  output logic [NUM_LANES*CODE_W-1:0] code_o,
  output logic [NUM_LANES-1:0]        limited_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [CODE_W-1:0] raw;
    assign raw          = code_i[l*CODE_W +: CODE_W];
    assign limited_o[l] = raw > EQ_MAX;
    assign code_o[l*CODE_W +: CODE_W] = limited_o[l] ? EQ_MAX : raw;

    always_comb begin
      p_code_bound_r5: assert (code_o[l*CODE_W +: CODE_W] <= EQ_MAX);
    end
  end
endmodule

// File: rtl/optmod_bringup.sv
module optmod_bringup
  import optmod_bringup_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 250_000_000,
  parameter int unsigned WAIT_MS = 2000
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        present_i,
  input  logic                        restart_i,
  input  logic [NUM_LANES*CODE_W-1:0] eq_code_i,
  input  logic                        wr_ack_i,
  input  logic                        wr_err_i,
  output logic                        lpmode_o,
  output logic                        modrst_no,
  output logic                        wr_req_o,
  output logic [7:0]                  wr_addr_o,
  output logic [7:0]                  wr_data_o,
  output logic                        done_o,
  output logic                        fault_o,
  output logic                        eq_clamp_o
);
  localparam int unsigned WAIT_CYCLES = CLK_HZ / 1000 * WAIT_MS;

  seq_state_e state_q, state_d;
  logic       wait_done;
  logic [NUM_LANES*CODE_W-1:0] code_lim;
  logic [NUM_LANES-1:0]        lane_lim;
  logic       clamp_q;

  optmod_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state_q == ST_WAIT && present_i),
    .expired_o (wait_done)
  );

  optmod_eq_clamp u_clamp (
    .code_i    (eq_code_i),
    .code_o    (code_lim),
    .limited_o (lane_lim)
  );

  assign wr_req_o = state_q inside {ST_TXDIS, ST_PAGE, ST_EQ_A, ST_EQ_B};

  always_comb begin
    state_d = state_q;
    if (!present_i) state_d = ST_HOLD;
    else begin
      unique case (state_q)
        ST_HOLD: state_d = ST_WAIT;
        ST_WAIT: if (wait_done) state_d = ST_TXDIS;
        ST_TXDIS, ST_PAGE, ST_EQ_A, ST_EQ_B: begin
          if (wr_err_i) state_d = ST_ERR;
          else if (wr_ack_i) begin
            unique case (state_q)
              ST_TXDIS: state_d = ST_PAGE;
              ST_PAGE:  state_d = ST_EQ_A;
              ST_EQ_A:  state_d = ST_EQ_B;
              default:  state_d = ST_DONE;
            endcase
          end
        end
        ST_ERR:  if (restart_i) state_d = ST_HOLD;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_HOLD;
    else         state_q <= state_d;
  end

  // lane 1 and lane 3 go to the upper nibble
  always_comb begin
    wr_addr_o = 8'h00;
    wr_data_o = 8'h00;
    unique case (state_q)
      ST_TXDIS: begin wr_addr_o = ADDR_TXDIS; wr_data_o = DATA_TXDIS; end
      ST_PAGE:  begin wr_addr_o = ADDR_PAGE;  wr_data_o = DATA_PAGE;  end
      ST_EQ_A:  begin wr_addr_o = ADDR_EQ_A;  wr_data_o = {code_lim[3:0],  code_lim[7:4]};   end
      ST_EQ_B:  begin wr_addr_o = ADDR_EQ_B;  wr_data_o = {code_lim[11:8], code_lim[15:12]}; end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clamp_q <= 1'b0;
    else if (present_i && wr_ack_i && !wr_err_i) begin
      if ((state_q == ST_EQ_A && (lane_lim[0] || lane_lim[1])) ||
          (state_q == ST_EQ_B && (lane_lim[2] || lane_lim[3])))
        clamp_q <= 1'b1;
    end
  end

  assign eq_clamp_o = clamp_q;
  assign lpmode_o   = state_q != ST_DONE;
  assign modrst_no  = !(state_q inside {ST_HOLD, ST_ERR});
  assign done_o     = state_q == ST_DONE;
  assign fault_o    = state_q == ST_ERR;

  p_req_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && !wr_ack_i && !wr_err_i && present_i |=> wr_req_o && $stable(wr_addr_o));
  p_flag_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_clamp_o |=> eq_clamp_o);
  p_fault_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o && !restart_i && present_i |=> fault_o && !wr_req_o);
  p_removal_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_i |=> !modrst_no && lpmode_o && !wr_req_o);
  p_err_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o && wr_err_i && present_i |=> fault_o);
  p_done_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && present_i |=> done_o && !wr_req_o && !lpmode_o);
endmodule

// File: tb/optmod_bringup_bench.sv
`timescale 1ns/1ps
module optmod_bringup_bench;
  localparam int unsigned CLK_HZ  = 1000;
  localparam int unsigned WAIT_MS = 20;
  localparam int unsigned N_WAIT  = CLK_HZ / 1000 * WAIT_MS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic present = 1'b0, restart = 1'b0, ack = 1'b0, err = 1'b0;
  logic [15:0] codes = 16'h0000;
  logic lpmode, modrst_n, req, done, fault, clampf;
  logic [7:0] addr, data;

  int checks = 0, errors = 0, cycles = 0;
  bit exp_clamp = 1'b0;

  always #2 clk = ~clk;

  optmod_bringup #(.CLK_HZ(CLK_HZ), .WAIT_MS(WAIT_MS)) u_optmod_bringup (
    .clk_i(clk), .rst_ni(rst_n), .present_i(present), .restart_i(restart),
    .eq_code_i(codes), .wr_ack_i(ack), .wr_err_i(err),
    .lpmode_o(lpmode), .modrst_no(modrst_n), .wr_req_o(req),
    .wr_addr_o(addr), .wr_data_o(data), .done_o(done), .fault_o(fault),
    .eq_clamp_o(clampf)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] lim(input logic [3:0] c);
    return (c > 4'd10) ? 4'd10 : c;
  endfunction

  task automatic check_hold(input string tag);
    check({lpmode, modrst_n, req, done, fault} == 5'b10000, tag,
          {27'd0, lpmode, modrst_n, req, done, fault}, 32'b10000);
  endtask

  task automatic serve(input logic [7:0] ea, input logic [7:0] ed, input string tag);
    int guard = 0;
    int dly;
    while (!req && guard < 50) begin @(negedge clk); guard++; end
    check(req, {tag, " request"}, 32'(req), 1);
    check(addr == ea, {tag, " addr R3"}, 32'(addr), 32'(ea));
    check(data == ed, {tag, " data R3 R5"}, 32'(data), 32'(ed));
    dly = int'($urandom_range(0, 3));
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      check(req && addr == ea, {tag, " held R4"}, {23'd0, req, addr}, {23'd1, ea});
    end
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // called with block in hold and visible at a negedge
  task automatic bring_up(input string tag);
    int n;
    logic [7:0] b_a, b_b;
    present = 1'b1;
    @(negedge clk);
    check(modrst_n && lpmode && !req, {tag, " reset released R2"},
          {29'd0, modrst_n, lpmode, req}, 32'b110);
    n = 1;
    while (!req && n < N_WAIT + 10) begin
      @(negedge clk);
      if (!req) n++;
    end
    check(n == N_WAIT, {tag, " wait length R2"}, n, N_WAIT);
    b_a = {lim(codes[3:0]),  lim(codes[7:4])};
    b_b = {lim(codes[11:8]), lim(codes[15:12])};
    serve(8'd86,  8'h0F, {tag, " txdis"});
    check(!done, {tag, " one write per ack R4"}, 32'(done), 0);
    serve(8'd127, 8'h03, {tag, " page"});
    serve(8'd234, b_a,   {tag, " eq234"});
    if (codes[3:0] > 10 || codes[7:4] > 10) exp_clamp = 1'b1;
    serve(8'd235, b_b,   {tag, " eq235"});
    if (codes[11:8] > 10 || codes[15:12] > 10) exp_clamp = 1'b1;
    check(done && !lpmode && modrst_n && !req, {tag, " done R7"},
          {28'd0, done, lpmode, modrst_n, req}, 32'b1010);
    check(clampf == exp_clamp, {tag, " clamp flag R6"}, 32'(clampf), 32'(exp_clamp));
    for (int i = 0; i < 6; i++) @(negedge clk);
    check(done && !req, {tag, " quiet after done R7"}, {30'd0, done, req}, 32'b10);
  endtask

  task automatic remove(input string tag);
    present = 1'b0;
    @(negedge clk);
    check_hold({tag, " removal R9"});
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #1;
    check_hold("reset R1");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    check_hold("absent hold R1");

    // in-range codes, directed boundary 0 and 10
    codes = 16'h3A05;
    bring_up("first");
    remove("after done");

    // reserved codes 11 and 15 limited to 10
    codes = 16'hB2F7;
    bring_up("reserved");
    remove("after reserved");

    // removal mid-wait
    present = 1'b1;
    for (int i = 0; i < 5; i++) @(negedge clk);
    remove("mid wait");

    // removal mid-write
    present = 1'b1;
    while (!req) @(negedge clk);
    remove("mid write");

    // bus error with simultaneous ack
    present = 1'b1;
    while (!req) @(negedge clk);
    err = 1'b1; ack = 1'b1;
    @(negedge clk);
    err = 1'b0; ack = 1'b0;
    check(fault && !req && !modrst_n && lpmode, "error state R8 R10",
          {28'd0, fault, req, modrst_n, lpmode}, 32'b1001);
    for (int i = 0; i < 8; i++) @(negedge clk);
    check(fault && !req, "error held R8", {30'd0, fault, req}, 32'b10);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check_hold("restart to hold R8");
    bring_up("after restart");

    // error on a later write
    remove("pre err2");
    present = 1'b1;
    while (!req) @(negedge clk);
    serve(8'd86, 8'h0F, "err2 txdis");
    err = 1'b1;
    @(negedge clk);
    err = 1'b0;
    check(fault, "error on page R8", 32'(fault), 1);

    // random passes
    for (int k = 0; k < 12; k++) begin
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      present = 1'b0;
      @(negedge clk);
      check_hold("random hold R9");
      codes = 16'($urandom);
      bring_up("random");
    end

    // reset clears sticky flag
    rst_n = 1'b0;
    #1;
    exp_clamp = 1'b0;
    check(!clampf, "flag cleared by reset R6", 32'(clampf), 0);
    check_hold("mid reset R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!clampf, "flag after reset R6", 32'(clampf), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule